// File: doc/BRIEF.md
# Interrupt Flag and Output Controller

This block gathers three kinds of events and turns them into one active-low interrupt pin. The events come from a periodic second/minute tick, a countdown timer reaching its end, and an alarm match. Each arrives as a one-cycle strobe. Each event latches a sticky flag inside an 8-bit control/status register. Software reads that register through a small synchronous register port.

Software clears the flags by writing to the register. Each flag bit takes the AND of its stored value and the written bit. A written 0 clears the flag and a written 1 leaves it alone. Software can therefore acknowledge one source without a read-modify-write race against the other sources. The remaining bits of that register are plain storage.

A second register holds one interrupt enable per source and a mode bit. The mode bit decides how the two timer-derived sources (tick and countdown) reach the pin:
- Level mode: the pin follows their flags.
- Pulse mode: each event produces a fixed-length low pulse.

The alarm always follows its flag.

The register port has no handshake. A write takes effect at the clock edge on which `reg_wr` is sampled high. A read is combinational from `reg_addr`. The port never stalls, so there is no back-pressure.

Top module: `intr_flag_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and `irq_n` is 1.
- R2: An event strobe sampled at a clock edge sets its flag from that edge onward. The flag positions in the status register (address 0) are: tick at bit 5, countdown at bit 2, alarm at bit 3. A flag stays set until software clears it.
- R3: A write to address 0 leaves each flag at (old value AND written bit). Writing 0 clears the flag and writing 1 leaves it unchanged.
- R4: Bits 7, 6, 4, 1 and 0 of address 0 are plain read/write storage. Writing the same value to them any number of times changes nothing.
- R5: If an event and a clearing write reach the same flag at the same edge, the flag ends up set.
- R6: Address 1 is the configuration register. Its fields are: bit 0 tick enable, bit 1 countdown enable, bit 2 alarm enable, bit 3 pulse mode (1 = pulse). Bits 7:4 read 0 and ignore writes. Any other address reads 0 and ignores writes.
- R7: In level mode, `irq_n` is low exactly when an enabled tick or countdown flag is set, or an enabled alarm flag is set.
- R8: In pulse mode, an event on an enabled tick or countdown source holds that source's request for exactly PULSE_CYCLES (default 4) cycles after the event edge. This does not depend on its flag. A new event restarts the count.
- R9: The alarm request follows the AF level whenever the alarm is enabled, in either mode.
- R10: A disabled source never drives `irq_n` low, but its flag is still set by its events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tick | input | 1 | One-cycle second/minute tick event |
| ev_timer | input | 1 | One-cycle countdown expiry event |
| ev_alarm | input | 1 | One-cycle alarm match event |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench drives an event into a flag on the same edge that writes a 0 to that flag. A design that let the clear win would silently drop an interrupt.

It writes all-ones to the flags while other flags are set. A plain-store design would wipe them, or would set flags that never saw an event.

It fires pulse-mode events, then clears the flag straight away and later retriggers. This exposes a pulse that is too short or too long, one that tracks the flag, or one that fails to restart. It also checks that the alarm still acts as a level in pulse mode and that disabled sources stay silent.

// File: rtl/intr_pkg.sv
package intr_pkg;

  localparam int REG_W = 8;

  // source indices
  localparam int IDX_TICK  = 0;
  localparam int IDX_TIMER = 1;
  localparam int IDX_ALARM = 2;
  localparam int NUM_SRC   = 3;
  localparam int NUM_TIMED = 2;  // sources that honour pulse mode

  // flag positions inside the status register
  localparam int TICK_POS  = 5;
  localparam int TIMER_POS = 2;
  localparam int ALARM_POS = 3;

  localparam logic [REG_W-1:0] FLAG_MASK =
    REG_W'((1 << TICK_POS) | (1 << TIMER_POS) | (1 << ALARM_POS));
  localparam logic [REG_W-1:0] PLAIN_MASK = ~FLAG_MASK;

  // register addresses
  localparam int STAT_ADDR = 0;
  localparam int CFG_ADDR  = 1;

  // configuration register, packed to match bits 3:0
  localparam int CFG_USED = 4;
  typedef struct packed {
    logic pulse_mode;  // bit 3
    logic alarm_en;    // bit 2
    logic timer_en;    // bit 1
    logic tick_en;     // bit 0
  } cfg_t;

  function automatic int flag_pos(input int idx);
    case (idx)
      IDX_TICK:  return TICK_POS;
      IDX_TIMER: return TIMER_POS;
      default:   return ALARM_POS;
    endcase
  endfunction

endpackage

// File: rtl/intr_flag_cell.sv
module intr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,     // event strobe
  input  logic wr_hit_i,  // status register write this cycle
  input  logic wbit_i,    // written value of this flag bit
  output logic flag_o
);
  logic keep;

  // AND-on-write; the event term has priority over any clearing write
  always_comb keep = flag_o & (~wr_hit_i | wbit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= set_i | keep;
  end
endmodule

// File: rtl/intr_pulse_stretch.sv
module intr_pulse_stretch #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (trig_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/intr_reg_bank.sv
module intr_reg_bank
  import intr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] flags_i,
  output logic              stat_wr_o,
  output cfg_t              cfg_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic             cfg_wr;
  logic [REG_W-1:0] plain_q;
  logic [REG_W-1:0] flag_vec;

  assign stat_wr_o = wr_i && (addr_i == ADDR_W'(STAT_ADDR));
  assign cfg_wr    = wr_i && (addr_i == ADDR_W'(CFG_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plain_q <= '0;
      cfg_o   <= '0;
    end else begin
      if (stat_wr_o) plain_q <= wdata_i & PLAIN_MASK;
      if (cfg_wr)    cfg_o   <= cfg_t'(wdata_i[CFG_USED-1:0]);
    end
  end

  always_comb begin
    flag_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) flag_vec[flag_pos(i)] = flags_i[i];
  end

  always_comb begin
    if (addr_i == ADDR_W'(STAT_ADDR))      rdata_o = plain_q | flag_vec;
    else if (addr_i == ADDR_W'(CFG_ADDR))  rdata_o = {{(REG_W-CFG_USED){1'b0}}, cfg_o};
    else                                   rdata_o = '0;
  end
endmodule

// File: rtl/intr_irq_merge.sv
module intr_irq_merge
  import intr_pkg::*;
(
  input  cfg_t                 cfg_i,
  input  logic [NUM_SRC-1:0]   flags_i,
  input  logic [NUM_TIMED-1:0] pulse_i,
  output logic                 irq_n_o
);
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] req;

  assign en[IDX_TICK]  = cfg_i.tick_en;
  assign en[IDX_TIMER] = cfg_i.timer_en;
  assign en[IDX_ALARM] = cfg_i.alarm_en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_req
    if (i < NUM_TIMED) begin : g_timed
      assign req[i] = en[i] & (cfg_i.pulse_mode ? pulse_i[i] : flags_i[i]);
    end else begin : g_level
      assign req[i] = en[i] & flags_i[i];
    end
  end

  assign irq_n_o = ~|req;
endmodule

// File: rtl/intr_flag_ctrl.sv
module intr_flag_ctrl
  import intr_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int PULSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tick,
  input  logic              ev_timer,
  input  logic              ev_alarm,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_n
);
  logic [NUM_SRC-1:0]   ev;
  logic [NUM_SRC-1:0]   flag_q;
  logic [NUM_TIMED-1:0] pulse_act;
  logic                 stat_wr;
  cfg_t                 cfg_q;

  assign ev[IDX_TICK]  = ev_tick;
  assign ev[IDX_TIMER] = ev_timer;
  assign ev[IDX_ALARM] = ev_alarm;

  intr_reg_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (reg_addr),
    .wr_i     (reg_wr),
    .wdata_i  (reg_wdata),
    .flags_i  (flag_q),
    .stat_wr_o(stat_wr),
    .cfg_o    (cfg_q),
    .rdata_o  (reg_rdata)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    intr_flag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ev[i]),
      .wr_hit_i(stat_wr),
      .wbit_i  (reg_wdata[flag_pos(i)]),
      .flag_o  (flag_q[i])
    );
  end

  for (genvar i = 0; i < NUM_TIMED; i++) begin : g_pulse
    intr_pulse_stretch #(.PULSE_CYCLES(PULSE_CYCLES)) u_stretch (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (ev[i]),
      .active_o(pulse_act[i])
    );
  end

  intr_irq_merge u_merge (
    .cfg_i  (cfg_q),
    .flags_i(flag_q),
    .pulse_i(pulse_act),
    .irq_n_o(irq_n)
  );
endmodule

// File: rtl/intr_flag_ctrl_chk.sv
module intr_flag_ctrl_chk
  import intr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_tick,
  input logic              ev_timer,
  input logic              ev_alarm,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              wd_tick,
  input logic              wd_timer,
  input logic              wd_alarm,
  input logic              irq_n,
  input logic [NUM_SRC-1:0] flags,
  input cfg_t              cfg
);
  logic stat_w, cfg_w;
  assign stat_w = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));
  assign cfg_w  = reg_wr && (reg_addr == ADDR_W'(CFG_ADDR));

  assert_tick_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tick |=> flags[IDX_TICK]);

  assert_alarm_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alarm |=> flags[IDX_ALARM]);

  assert_and_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w && !wd_tick && !ev_tick) |=> !flags[IDX_TICK]);

  assert_and_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w && wd_alarm && !ev_alarm) |=> (flags[IDX_ALARM] == $past(flags[IDX_ALARM])));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_timer && stat_w && !wd_timer) |=> flags[IDX_TIMER]);

  assert_level_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.pulse_mode && cfg.timer_en && flags[IDX_TIMER]) |-> !irq_n);

  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pulse_mode && cfg.tick_en && ev_tick && !cfg_w) |=> !irq_n);

  assert_alarm_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.alarm_en && flags[IDX_ALARM]) |-> !irq_n);

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == '0) |-> irq_n);
endmodule

bind intr_flag_ctrl intr_flag_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ev_tick (ev_tick),
  .ev_timer(ev_timer),
  .ev_alarm(ev_alarm),
  .reg_addr(reg_addr),
  .reg_wr  (reg_wr),
  .wd_tick (reg_wdata[intr_pkg::TICK_POS]),
  .wd_timer(reg_wdata[intr_pkg::TIMER_POS]),
  .wd_alarm(reg_wdata[intr_pkg::ALARM_POS]),
  .irq_n   (irq_n),
  .flags   (flag_q),
  .cfg     (cfg_q)
);

// File: tb/test_intr_flag_ctrl.sv
module test_intr_flag_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_tick = 1'b0, ev_timer = 1'b0, ev_alarm = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  // bench model
  logic [7:0] m_stat = '0;
  logic [3:0] m_cfg  = '0;
  int         m_cnt [2] = '{0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_flag_ctrl #(.ADDR_W(2), .PULSE_CYCLES(PULSE)) i_intr_flag_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ev_tick(ev_tick), .ev_timer(ev_timer), .ev_alarm(ev_alarm),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  function automatic int pos_of(input int i);
    return (i == 0) ? 5 : (i == 1) ? 2 : 3;
  endfunction

  function automatic logic [7:0] model_read(input logic [1:0] a);
    if (a == 2'd0) return m_stat;
    if (a == 2'd1) return {4'h0, m_cfg};
    return 8'h00;
  endfunction

  function automatic logic model_irq_n();
    logic r0, r1, r2;
    r0 = m_cfg[0] && (m_cfg[3] ? (m_cnt[0] != 0) : m_stat[5]);
    r1 = m_cfg[1] && (m_cfg[3] ? (m_cnt[1] != 0) : m_stat[2]);
    r2 = m_cfg[2] && m_stat[3];
    return !(r0 || r1 || r2);
  endfunction

  task automatic model_step(input logic [1:0] a, input logic w,
                            input logic [7:0] d, input logic [2:0] ev);
    logic       sw;
    logic [7:0] nxt;
    sw  = w && (a == 2'd0);
    nxt = sw ? (d & 8'hD3) : (m_stat & 8'hD3);
    for (int i = 0; i < 3; i++) begin
      int p;
      p = pos_of(i);
      nxt[p] = ev[i] || (m_stat[p] && (!sw || d[p]));
    end
    m_stat = nxt;
    if (w && a == 2'd1) m_cfg = d[3:0];
    for (int i = 0; i < 2; i++) begin
      if (ev[i])           m_cnt[i] = PULSE;
      else if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
    end
  endtask

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, got, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check, then advance model at posedge
  task automatic cyc(input logic [1:0] a, input logic w,
                     input logic [7:0] d, input logic [2:0] ev);
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_wdata = d;
    ev_tick = ev[0]; ev_timer = ev[1]; ev_alarm = ev[2];
    #1;
    chk("rdata", reg_rdata, model_read(a));
    chk("irq_n", {7'd0, irq_n}, {7'd0, model_irq_n()});
    @(posedge clk);
    model_step(a, w, d, ev);
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) cyc(a, 1'b0, 8'h00, 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd90210));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    cur_tag = "R1";
    cyc(2'd0, 1'b0, 8'h00, 3'b000);
    cyc(2'd1, 1'b0, 8'h00, 3'b000);

    // R2 each event latches and holds its flag
    cur_tag = "R2";
    cyc(2'd0, 1'b0, 8'h00, 3'b001);
    cyc(2'd0, 1'b0, 8'h00, 3'b010);
    cyc(2'd0, 1'b0, 8'h00, 3'b100);
    idle(3, 2'd0);

    // R3 writing ones keeps flags, zero clears one only
    cur_tag = "R3";
    cyc(2'd0, 1'b1, 8'hFF, 3'b000);
    cyc(2'd0, 1'b1, 8'hFB, 3'b000);
    cyc(2'd0, 1'b1, 8'hDF, 3'b000);
    idle(2, 2'd0);

    // R4 plain bits, repeated identical writes
    cur_tag = "R4";
    for (int i = 0; i < 3; i++) cyc(2'd0, 1'b1, 8'hD3, 3'b000);
    cyc(2'd0, 1'b1, 8'h10, 3'b000);
    idle(2, 2'd0);

    // R5 event beats same-edge clear
    cur_tag = "R5";
    cyc(2'd0, 1'b1, 8'h00, 3'b111);
    idle(2, 2'd0);
    cyc(2'd0, 1'b1, 8'h00, 3'b010);
    idle(1, 2'd0);

    // R6 config upper bits and unmapped addresses
    cur_tag = "R6";
    cyc(2'd1, 1'b1, 8'hF0, 3'b000);
    idle(1, 2'd1);
    cyc(2'd2, 1'b1, 8'hFF, 3'b000);
    cyc(2'd3, 1'b1, 8'hFF, 3'b000);
    idle(1, 2'd2);
    idle(1, 2'd1);
    idle(1, 2'd0);

    // R7 level mode follows flags
    cur_tag = "R7";
    cyc(2'd0, 1'b1, 8'h00, 3'b000);
    cyc(2'd1, 1'b1, 8'h03, 3'b000);
    cyc(2'd0, 1'b0, 8'h00, 3'b010);
    idle(3, 2'd0);
    cyc(2'd0, 1'b1, 8'hFB, 3'b000);
    cyc(2'd0, 1'b0, 8'h00, 3'b001);
    idle(2, 2'd0);
    cyc(2'd0, 1'b1, 8'h00, 3'b000);
    idle(1, 2'd0);

    // R8 pulse length, flag-independent, retrigger
    cur_tag = "R8";
    cyc(2'd1, 1'b1, 8'h09, 3'b000);
    cyc(2'd0, 1'b0, 8'h00, 3'b001);
    cyc(2'd0, 1'b1, 8'h00, 3'b000);
    idle(PULSE + 2, 2'd0);
    cyc(2'd0, 1'b0, 8'h00, 3'b001);
    idle(2, 2'd0);
    cyc(2'd0, 1'b0, 8'h00, 3'b001);
    idle(PULSE + 2, 2'd0);
    cyc(2'd1, 1'b1, 8'h0A, 3'b000);
    cyc(2'd0, 1'b0, 8'h00, 3'b010);
    idle(PULSE + 2, 2'd0);

    // R9 alarm stays a level in pulse mode
    cur_tag = "R9";
    cyc(2'd0, 1'b1, 8'h00, 3'b000);
    cyc(2'd1, 1'b1, 8'h0C, 3'b000);
    cyc(2'd0, 1'b0, 8'h00, 3'b100);
    idle(PULSE + 3, 2'd0);
    cyc(2'd0, 1'b1, 8'hF7, 3'b000);
    idle(2, 2'd0);

    // R10 disabled sources stay quiet yet flag
    cur_tag = "R10";
    cyc(2'd1, 1'b1, 8'h08, 3'b000);
    cyc(2'd0, 1'b0, 8'h00, 3'b111);
    idle(PULSE + 2, 2'd0);
    cyc(2'd1, 1'b1, 8'h00, 3'b111);
    idle(3, 2'd0);

    // random mix covering R2 R3 R4 R5 R7 R8 R9 R10
    cur_tag = "R2 R3 R7 R8 R9 R10 random";
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a;
      logic       w;
      logic [7:0] d;
      logic [2:0] ev;
      a  = 2'($urandom_range(3, 0));
      w  = ($urandom_range(2, 0) == 0);
      d  = 8'($urandom);
      ev = {($urandom_range(5, 0) == 0), ($urandom_range(5, 0) == 0),
            ($urandom_range(5, 0) == 0)};
      cyc(a, w, d, ev);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule